// File: doc/BRIEF.md
# Host Remote DMA Engine

This block moves data between a host data port and a local packet memory. The host first loads a 16-bit start address and a 16-bit byte count, each as a low byte and a high byte. It then writes a command byte that starts a read transfer, starts a write transfer, or aborts. While a transfer runs, each read strobe on the data port returns the next memory location, and each write strobe stores into the next location. After each access the current address and the remaining count both move forward.

A configuration bit picks byte or word width. In word mode one access moves two bytes, with the low byte at the lower address, and the address and count step by 2. When the remaining count runs out, a completion flag is set in the status register. The host clears that flag by writing a 1 to its bit. The current address can be read back at any time. An abort ends a transfer without setting the completion flag.

Register offsets on `regAddr`: 0 command, 1 start address low, 2 start address high, 3 byte count low, 4 byte count high, 5 current address low, 6 current address high, 7 status, 8 configuration.

Top module: `rdma_engine`

## Requirements
- R1: After reset the status register reads 0x00, the current address reads 0x0000, data-port reads return zero and no memory write is issued.
- R2: Offsets 1/2 load the start address (low/high byte) and offsets 3/4 load the byte count. A start command copies the start address into the current address, which reads back on offsets 5/6 before any access.
- R3: The command field is bits 5:3 of the byte written to offset 0. 001 starts a read, 010 starts a write, and any value with bit 5 set aborts. 011 and 000 start no transfer.
- R4: In byte mode (configuration bit 0 = 0) each access moves one byte on memory data bits 7:0, the address rises by 1 and the count falls by 1.
- R5: In word mode (configuration bit 0 = 1) each access moves 16 bits, with the low byte at the lower address. The address rises by 2 and the count falls by 2. An access made when 1 byte remains ends the transfer.
- R6: Status bit 6 is set on the access that brings the remaining count to zero, and not before.
- R7: Writing offset 7 with bit 6 set clears the completion bit. Writing it with bit 6 clear leaves the bit unchanged.
- R8: An abort command stops a running transfer without setting the completion bit. The current address keeps its value.
- R9: While no transfer is active, data-port writes leave memory unchanged and data-port reads return zero.
- R10: A start command given with a byte count of zero sets the completion bit at once and moves no data.
- R11: The current address wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register offset |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| dpRd | input | 1 | Data-port read strobe |
| dpWr | input | 1 | Data-port write strobe |
| dpWrData | input | 16 | Data-port write data |
| dpRdData | output | 16 | Data-port read data (combinational) |
| memAddr | output | 16 | Memory byte address |
| memWrEn | output | 1 | Memory write enable |
| memWide | output | 1 | Write covers two bytes (addr and addr+1) |
| memWrData | output | 16 | Memory write data |
| memRdData | input | 16 | Memory read data: {byte addr+1, byte addr} |

## Verification
Four transfer patterns are each written through the data port and then read back. The first is byte mode with an odd count. The second is word mode with an even count. The third is word mode with an odd count, which shows whether a half-filled last word ends the transfer. The fourth is byte mode starting at 0xFFFE, which shows whether the address wraps. For each pattern the bench checks the final address, the memory contents and the timing of the completion flag, so a wrong step size, a wrong byte lane or an off-by-one end of transfer each show up in a different check. Directed tests cover abort, a zero count, the non-transfer command codes, the write-1-to-clear rule and accesses made while idle.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [3:0] REG_CMD     = 4'd0;
  localparam logic [3:0] REG_STARTLO = 4'd1;
  localparam logic [3:0] REG_STARTHI = 4'd2;
  localparam logic [3:0] REG_CNTLO   = 4'd3;
  localparam logic [3:0] REG_CNTHI   = 4'd4;
  localparam logic [3:0] REG_CURLO   = 4'd5;
  localparam logic [3:0] REG_CURHI   = 4'd6;
  localparam logic [3:0] REG_STATUS  = 4'd7;
  localparam logic [3:0] REG_CFG     = 4'd8;

  localparam int DONE_BIT = 6;

  typedef struct packed {
    logic ldStartLo;
    logic ldStartHi;
    logic ldCntLo;
    logic ldCntHi;
    logic beginXfer;
    logic step;
    logic wide;
  } rdmaStrobes_t;
endpackage

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdmaStrobes_t      strb,
  input  logic [7:0]        wrData,
  output logic [ADDR_W-1:0] startAddr,
  output logic [CNT_W-1:0]  byteCount,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lastStep,
  output logic              cntZero
);
  localparam int AHI_W = ADDR_W - 8;
  localparam int CHI_W = CNT_W - 8;

  logic [CNT_W-1:0]  remaining;
  logic [CNT_W-1:0]  stepCnt;
  logic [ADDR_W-1:0] stepAddr;

  assign stepCnt  = strb.wide ? CNT_W'(2) : CNT_W'(1);
  assign stepAddr = strb.wide ? ADDR_W'(2) : ADDR_W'(1);
  assign lastStep = (remaining <= stepCnt);
  assign cntZero  = (byteCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      byteCount <= '0;
      curAddr   <= '0;
      remaining <= '0;
    end else begin
      if (strb.ldStartLo) startAddr[7:0]        <= wrData;
      if (strb.ldStartHi) startAddr[ADDR_W-1:8] <= wrData[AHI_W-1:0];
      if (strb.ldCntLo)   byteCount[7:0]        <= wrData;
      if (strb.ldCntHi)   byteCount[CNT_W-1:8]  <= wrData[CHI_W-1:0];
      if (strb.beginXfer) begin
        curAddr   <= startAddr;
        remaining <= byteCount;
      end else if (strb.step) begin
        curAddr   <= curAddr + stepAddr;
        remaining <= lastStep ? '0 : remaining - stepCnt;
      end
    end
  end
endmodule

// File: rtl/rdma_control.sv
module rdma_control
  import rdma_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   regAddr,
  input  logic         regWr,
  input  logic [7:0]   regWrData,
  input  logic         dpRd,
  input  logic         dpWr,
  input  logic         lastStep,
  input  logic         cntZero,
  output rdmaStrobes_t strb,
  output logic         xferActive,
  output logic         xferIsWrite,
  output logic         doneFlag,
  output logic         wideMode,
  output logic [7:0]   cmdReg
);
  logic       cmdHit;
  logic [2:0] cmdField;
  logic       startRd, startWr, abortCmd, xferGo, access;
  logic       setDone, clrDone;

  assign cmdHit   = regWr && (regAddr == REG_CMD);
  assign cmdField = regWrData[5:3];
  assign startRd  = cmdHit && (cmdField == 3'b001);
  assign startWr  = cmdHit && (cmdField == 3'b010);
  assign abortCmd = cmdHit && cmdField[2];
  assign xferGo   = startRd || startWr;
  assign access   = xferActive && !cmdHit && (xferIsWrite ? dpWr : dpRd);

  assign setDone = (xferGo && cntZero) || (access && lastStep);
  assign clrDone = regWr && (regAddr == REG_STATUS) && regWrData[DONE_BIT];

  always_comb begin
    strb           = '0;
    strb.ldStartLo = regWr && (regAddr == REG_STARTLO);
    strb.ldStartHi = regWr && (regAddr == REG_STARTHI);
    strb.ldCntLo   = regWr && (regAddr == REG_CNTLO);
    strb.ldCntHi   = regWr && (regAddr == REG_CNTHI);
    strb.beginXfer = xferGo;
    strb.step      = access;
    strb.wide      = wideMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferActive  <= 1'b0;
      xferIsWrite <= 1'b0;
      doneFlag    <= 1'b0;
      wideMode    <= 1'b0;
      cmdReg      <= '0;
    end else begin
      if (cmdHit) cmdReg <= regWrData;
      if (regWr && (regAddr == REG_CFG)) wideMode <= regWrData[0];
      if (abortCmd) xferActive <= 1'b0;
      else if (xferGo) begin
        xferActive  <= !cntZero;
        xferIsWrite <= startWr;
      end else if (access && lastStep) xferActive <= 1'b0;
      if (setDone) doneFlag <= 1'b1;
      else if (clrDone) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              dpRd,
  input  logic              dpWr,
  input  logic [15:0]       dpWrData,
  output logic [15:0]       dpRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic              memWide,
  output logic [15:0]       memWrData,
  input  logic [15:0]       memRdData
);
  localparam int AHI_W = ADDR_W - 8;
  localparam int CHI_W = CNT_W - 8;

  rdmaStrobes_t      strb;
  logic              xferActive, xferIsWrite, doneFlag, wideMode;
  logic              lastStep, cntZero, stepNow;
  logic [7:0]        cmdReg;
  logic [ADDR_W-1:0] startAddr, curAddr;
  logic [CNT_W-1:0]  byteCount;

  rdma_control u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .dpRd(dpRd), .dpWr(dpWr),
    .lastStep(lastStep), .cntZero(cntZero), .strb(strb),
    .xferActive(xferActive), .xferIsWrite(xferIsWrite),
    .doneFlag(doneFlag), .wideMode(wideMode), .cmdReg(cmdReg)
  );

  rdma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .startAddr(startAddr), .byteCount(byteCount), .curAddr(curAddr),
    .lastStep(lastStep), .cntZero(cntZero)
  );

  assign stepNow   = strb.step;
  assign memAddr   = curAddr;
  assign memWide   = wideMode;
  assign memWrData = dpWrData;
  assign memWrEn   = stepNow && xferIsWrite;

  always_comb begin
    if (xferActive && !xferIsWrite)
      dpRdData = wideMode ? memRdData : {8'h00, memRdData[7:0]};
    else
      dpRdData = '0;
  end

  always_comb begin
    case (regAddr)
      REG_CMD:     regRdData = cmdReg;
      REG_STARTLO: regRdData = startAddr[7:0];
      REG_STARTHI: regRdData = 8'(startAddr[ADDR_W-1:8]);
      REG_CNTLO:   regRdData = byteCount[7:0];
      REG_CNTHI:   regRdData = 8'(byteCount[CNT_W-1:8]);
      REG_CURLO:   regRdData = curAddr[7:0];
      REG_CURHI:   regRdData = 8'(curAddr[ADDR_W-1:8]);
      REG_STATUS:  regRdData = 8'(doneFlag) << DONE_BIT;
      REG_CFG:     regRdData = {7'd0, wideMode};
      default:     regRdData = '0;
    endcase
  end

  logic unusedBits;
  assign unusedBits = ^{memRdData[15:8] & 8'h00, AHI_W[0], CHI_W[0]};
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        regAddr,
  input logic              regWr,
  input logic [7:0]        regWrData,
  input logic              dpWr,
  input logic              memWrEn,
  input logic              memWide,
  input logic              stepNow,
  input logic              xferActive,
  input logic              doneFlag,
  input logic [ADDR_W-1:0] curAddr
);
  // R9
  no_idle_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (dpWr && xferActive));

  // R4
  byte_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && !memWide) |=> (curAddr == $past(curAddr) + ADDR_W'(1)));

  // R5
  word_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && memWide) |=> (curAddr == $past(curAddr) + ADDR_W'(2)));

  // R8
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 4'd0 && regWrData[5])
      |=> (!xferActive && doneFlag == $past(doneFlag)));

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(xferActive || (regWr && regAddr == 4'd0)));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 4'd7 && regWrData[6] && !xferActive) |=> !doneFlag);
endmodule

bind rdma_engine rdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
  .regWrData(regWrData), .dpWr(dpWr), .memWrEn(memWrEn),
  .memWide(memWide), .stepNow(stepNow), .xferActive(xferActive),
  .doneFlag(doneFlag), .curAddr(curAddr)
);

// File: tb/rdma_engine_test.sv
`timescale 1ns/1ps
module rdma_engine_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        dpRd = 0, dpWr = 0;
  logic [15:0] dpWrData = '0, dpRdData;
  logic [15:0] memAddr, memWrData, memRdData;
  logic        memWrEn, memWide;
  logic [7:0]  mem [0:65535];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rdma_engine uut (.*);

  assign memRdData = {mem[memAddr + 16'd1], mem[memAddr]};
  always_ff @(posedge clk)
    if (memWrEn) begin
      mem[memAddr] <= memWrData[7:0];
      if (memWide) mem[memAddr + 16'd1] <= memWrData[15:8];
    end

  // {wide, start, count}
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 16'h1230, 16'd5},
    {1'b1, 16'h2000, 16'd8},
    {1'b1, 16'h30F0, 16'd7},
    {1'b0, 16'hFFFE, 16'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regW(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regData(d); regWr = 1;
    @(negedge clk); regWr = 0;
  endtask
  task automatic regData(input logic [7:0] d); regWrData = d; endtask

  task automatic regR(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #0.5 d = regRdData;
  endtask

  task automatic curR(output logic [15:0] v);
    logic [7:0] lo, hi;
    regR(4'd5, lo); regR(4'd6, hi); v = {hi, lo};
  endtask

  task automatic dpW(input logic [15:0] d);
    @(negedge clk); dpWrData = d; dpWr = 1;
    @(negedge clk); dpWr = 0;
  endtask

  task automatic dpR(output logic [15:0] d);
    @(negedge clk); dpRd = 1; #0.5 d = dpRdData;
    @(negedge clk); dpRd = 0;
  endtask

  task automatic setup(input bit w, input logic [15:0] s, input logic [15:0] c);
    regW(4'd8, {7'd0, w});
    regW(4'd1, s[7:0]); regW(4'd2, s[15:8]);
    regW(4'd3, c[7:0]); regW(4'd4, c[15:8]);
  endtask

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'((v * 16 + i * 3 + 1) & 8'hFF);
  endfunction

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] v, a16;
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    regR(4'd7, r); check(r == 8'h00, "R1 status", r, 0);
    curR(v); check(v == 16'h0000, "R1 curAddr", v, 0);
    dpR(v); check(v == 16'h0000, "R1 dp read", v, 0);

    for (int k = 0; k < 4; k++) begin
      bit w; logic [15:0] s, c; int n, st;
      {w, s, c} = VEC[k];
      st = w ? 2 : 1;
      n = w ? (int'(c) + 1) / 2 : int'(c);
      setup(w, s, c);
      regW(4'd0, 8'h12);
      curR(v); check(v == s, "R2 cur after start", v, s);
      for (int i = 0; i < n; i++) begin
        if (i == n - 1) begin
          regR(4'd7, r); check(r == 8'h00, "R6 not early", r, 0);
        end
        dpW(w ? {pat(k, 2*i+1), pat(k, 2*i)} : {8'hEE, pat(k, i)});
      end
      regR(4'd7, r); check(r == 8'h40, "R6 done set", r, 8'h40);
      curR(v); a16 = s + 16'(n * st);
      check(v == a16, "R4/R5/R11 final addr", v, a16);
      for (int i = 0; i < n * st; i++) begin
        logic [15:0] ai; ai = s + 16'(i);
        check(mem[ai] == pat(k, i), w ? "R5 mem byte" : "R4 mem byte", mem[ai], pat(k, i));
      end
      if (!w) check(mem[a16] == 8'h00, "R4 no extra byte", mem[a16], 0);
      regW(4'd7, 8'h40);
      regR(4'd7, r); check(r == 8'h00, "R7 clear", r, 0);
      regW(4'd0, 8'h0A);
      for (int i = 0; i < n; i++) begin
        logic [15:0] e;
        e = w ? {pat(k, 2*i+1), pat(k, 2*i)} : {8'h00, pat(k, i)};
        dpR(v); check(v == e, w ? "R5 read data" : "R4 read data", v, e);
      end
      regR(4'd7, r); check(r == 8'h40, "R6 read done", r, 8'h40);
      dpR(v); check(v == 16'h0000, "R9 read after done", v, 0);
      regW(4'd7, 8'h00);
      regR(4'd7, r); check(r == 8'h40, "R7 write zero keeps", r, 8'h40);
      regW(4'd7, 8'h40);
    end

    // R8 abort
    setup(1'b0, 16'h4000, 16'd10);
    regW(4'd0, 8'h12);
    dpW(16'h0011); dpW(16'h0022);
    regW(4'd0, 8'h22);
    regR(4'd7, r); check(r == 8'h00, "R8 no done", r, 0);
    curR(v); check(v == 16'h4002, "R8 addr kept", v, 16'h4002);
    dpW(16'h0033);
    check(mem[16'h4002] == 8'h00, "R8/R9 write ignored", mem[16'h4002], 0);
    dpR(v); check(v == 16'h0000, "R9 idle read", v, 0);

    // R3 codes 011 and 000 start nothing
    setup(1'b0, 16'h5000, 16'd4);
    regW(4'd0, 8'h1A);
    dpW(16'h0055);
    check(mem[16'h5000] == 8'h00, "R3 code 011", mem[16'h5000], 0);
    regW(4'd0, 8'h02);
    dpW(16'h0066);
    check(mem[16'h5000] == 8'h00, "R3 code 000", mem[16'h5000], 0);
    regR(4'd7, r); check(r == 8'h00, "R3 no done", r, 0);

    // R10 zero count
    setup(1'b0, 16'h6000, 16'd0);
    regW(4'd0, 8'h12);
    regR(4'd7, r); check(r == 8'h40, "R10 done at once", r, 8'h40);
    dpW(16'h0077);
    check(mem[16'h6000] == 8'h00, "R10 no data", mem[16'h6000], 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule